// File: doc/BRIEF.md
# UART Register Bank with Interrupt Identification

This block is the host-facing register file of a classic byte-wide asynchronous serial controller. A host reaches it over a small bus with eight byte registers. The bus has a 3-bit offset, separate read and write strobes, a write data byte and a read data byte. The block holds:

- the two divisor bytes;
- the interrupt enable register;
- the line control, modem control and scratch registers;
- the line status and modem status registers.

It also keeps four interrupt sources: line status, receive data, transmitter empty and modem status. From those it derives an encoded identification value and a level interrupt line.

Received bytes arrive on a byte port with a one-cycle valid strobe. Each byte written to the transmit data register leaves on a byte port with a one-cycle strobe. Bit timing, baud generation and FIFO depth logic sit outside the block. The divisor bytes are only stored here and read back.

Register writes take effect at the clock edge where the write strobe is sampled high. A read returns, during its strobe cycle, the state held before that edge. The side effects of a read are applied at that same edge. The host never asserts read and write together. A received byte is never presented in a cycle that has a register access.

Top module: `uart_rb_top`

## Requirements
- R1: After reset:
  - identification reads 0x01;
  - line status reads 0x60;
  - interrupt enable, line control and modem control read 0x00;
  - `irq_o` is low.
- R2: While line control bit 7 is set, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte. A write to offset 0 in that state emits no transmit strobe.
- R3: A write to offset 1 (line control bit 7 clear) stores only bits 3:0; bits 7:4 read back as 0. The enable bits are: bit0 receive, bit1 transmitter empty, bit2 line status, bit3 modem status.
- R4: The identification value at offset 2 reports the highest-priority source that is both pending and enabled, with bit0 clear:
  - line status gives 0x06;
  - receive data gives 0x04;
  - transmitter empty gives 0x02;
  - modem status gives 0x00.
  A change to a flag or an enable bit shows in the next read, with no extra delay.
- R5: With no source both pending and enabled, identification reads 0x01.
- R6: Reading offset 2 while it reports 0x02 clears the transmitter-empty pending flag. Reading it with any other code leaves that flag unchanged.
- R7: When bit0 of the last byte written to offset 2 is 1, identification reads return bits 7:6 as 1.
- R8: `irq_o` is high exactly when identification bit0 is 0 and modem control bit 3 is set.
- R9: A write to offset 0 with line control bit 7 clear has four effects:
  - it sets line status bit 5;
  - it raises the transmitter-empty pending flag;
  - it drives `tx_data_o` with the byte;
  - it drives `tx_valid_o` high for the following cycle.
- R10: A valid received byte sets line status bit 0 and the receive pending flag. A read of offset 0 (line control bit 7 clear) returns the byte and clears both.
- R11: A read of offset 5 returns:
  - bit 6 as 1 if bit 5 was already set, otherwise as its stored value;
  - bit 5 as 1;
  - the remaining bits as stored.
  It then keeps bits 6 and 5 as returned, clears bits 4:1 and clears the line status pending flag. A write to offset 5 loads the register. Bit0 of the written byte raises receive pending, any of bits 4:1 raises line status pending, and bit5 raises transmitter-empty pending.
- R12: A write to offset 6 loads modem status, and a nonzero bits 3:0 raises modem status pending. A read of offset 6 returns the value, then clears bits 3:0 and the modem status pending flag.
- R13: Offset 7 is a plain read/write byte. Offsets 3 and 4 read back the full byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid during the read strobe |
| rx_data_i | input | DW | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| tx_data_o | output | DW | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench uses the defaults, DW = 8 and AW = 3. This covers the full eight-offset map and every identification code. The bench keeps a shadow of every register and pending flag. With it, a long random mix of accesses is scored on every read and on the interrupt line:

- divisor-latch access switched on and off;
- arbitrary enable masks;
- gating by modem control bit 3;
- received bytes arriving between accesses.

Directed sequences add reset values, the full priority walk-down, and the read-to-clear of each source.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_IEN  = 1;
  localparam int unsigned OFF_IID  = 2;
  localparam int unsigned OFF_LCTL = 3;
  localparam int unsigned OFF_MCTL = 4;
  localparam int unsigned OFF_LSTS = 5;
  localparam int unsigned OFF_MSTS = 6;
  localparam int unsigned OFF_SCR  = 7;

  // pending / enable index
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_TX = 1;
  localparam int unsigned SRC_LS = 2;
  localparam int unsigned SRC_MS = 3;
  localparam int unsigned NSRC   = 4;

  localparam logic [2:0] CODE_LS = 3'd3;
  localparam logic [2:0] CODE_RX = 3'd2;
  localparam logic [2:0] CODE_TX = 3'd1;
  localparam logic [2:0] CODE_MS = 3'd0;

  localparam logic [7:0] LSTS_RST = 8'h60;
endpackage

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] ien_i,
  input  logic            gate_i,
  output logic [3:0]      iid_o,
  output logic            irq_o
);
  logic [NSRC-1:0] act;
  assign act = pend_i & ien_i;

  always_comb begin
    iid_o = 4'b0001;
    if      (act[SRC_LS]) iid_o = {CODE_LS, 1'b0};
    else if (act[SRC_RX]) iid_o = {CODE_RX, 1'b0};
    else if (act[SRC_TX]) iid_o = {CODE_TX, 1'b0};
    else if (act[SRC_MS]) iid_o = {CODE_MS, 1'b0};
  end

  assign irq_o = ~iid_o[0] & gate_i;
endmodule

// File: rtl/uart_rb_pend.sv
module uart_rb_pend
  import uart_rb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[g] <= 1'b0;
      else if (set_i[g])  pend_o[g] <= 1'b1;  // set wins
      else if (clr_i[g])  pend_o[g] <= 1'b0;
    end

    AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);                               // R4
    AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);               // R6
  end
endmodule

// File: rtl/uart_rb_lsr.sv
module uart_rb_lsr
  import uart_rb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          thr_wr_i,
  input  logic          rbr_rd_i,
  input  logic          rx_push_i,
  input  logic          rd_i,
  output logic [DW-1:0] lsts_o,
  output logic [DW-1:0] rd_val_o
);
  logic [DW-1:0] lsts_q, lsts_d;

  // read view: TEMT follows prior THRE, THRE forced
  always_comb begin
    rd_val_o    = lsts_q;
    rd_val_o[6] = lsts_q[6] | lsts_q[5];
    rd_val_o[5] = 1'b1;
  end

  always_comb begin
    lsts_d = lsts_q;
    if (load_i) lsts_d = wdata_i;
    else if (rd_i) begin
      lsts_d      = rd_val_o;
      lsts_d[4:1] = '0;
    end else begin
      if (thr_wr_i)  lsts_d[5] = 1'b1;
      if (rx_push_i) lsts_d[0] = 1'b1;
      else if (rbr_rd_i) lsts_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lsts_q <= DW'(LSTS_RST);
    else         lsts_q <= lsts_d;
  end

  assign lsts_o = lsts_q;

  AST_LSR_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i) |=> (lsts_q[4:1] == 4'd0 && lsts_q[5]));          // R11
  AST_TEMT_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i && lsts_q[5]) |=> lsts_q[6]);                      // R11
  AST_THRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !load_i) |=> lsts_q[5]);                               // R9
  AST_DR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbr_rd_i && !rx_push_i && !load_i && !rd_i) |=> !lsts_q[0]);       // R10
endmodule

// File: rtl/uart_rb_top.sv
module uart_rb_top
  import uart_rb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          irq_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0]   dll_q, dlm_q, lctl_q, mctl_q, scr_q, rbr_q, msts_q, lsts, lsts_rd;
  logic [NSRC-1:0] ien_q, pend, pset, pclr;
  logic            fen_q;
  logic [3:0]      iid;
  logic [NREG-1:0] sel;
  logic            dlab;

  assign dlab = lctl_q[7];
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign sel[g] = (addr_i == AW'(g));
  end

  logic wr_thr, wr_dll, wr_dlm, wr_ien, wr_lsts, wr_msts;
  logic rd_rbr, rd_iid, rd_lsts, rd_msts;
  assign wr_thr  = wr_i & sel[OFF_DATA] & ~dlab;
  assign wr_dll  = wr_i & sel[OFF_DATA] &  dlab;
  assign wr_ien  = wr_i & sel[OFF_IEN]  & ~dlab;
  assign wr_dlm  = wr_i & sel[OFF_IEN]  &  dlab;
  assign wr_lsts = wr_i & sel[OFF_LSTS];
  assign wr_msts = wr_i & sel[OFF_MSTS];
  assign rd_rbr  = rd_i & sel[OFF_DATA] & ~dlab;
  assign rd_iid  = rd_i & sel[OFF_IID];
  assign rd_lsts = rd_i & sel[OFF_LSTS];
  assign rd_msts = rd_i & sel[OFF_MSTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q <= '0; dlm_q <= '0; ien_q <= '0; fen_q <= 1'b0;
      lctl_q <= '0; mctl_q <= '0; scr_q <= '0; rbr_q <= '0; msts_q <= '0;
      tx_data_o <= '0; tx_valid_o <= 1'b0;
    end else begin
      tx_valid_o <= wr_thr;
      if (wr_thr)                         tx_data_o <= wdata_i;
      if (wr_dll)                         dll_q  <= wdata_i;
      if (wr_dlm)                         dlm_q  <= wdata_i;
      if (wr_ien)                         ien_q  <= wdata_i[NSRC-1:0];
      if (wr_i && sel[OFF_IID])           fen_q  <= wdata_i[0];
      if (wr_i && sel[OFF_LCTL])          lctl_q <= wdata_i;
      if (wr_i && sel[OFF_MCTL])          mctl_q <= wdata_i;
      if (wr_i && sel[OFF_SCR])           scr_q  <= wdata_i;
      if (rx_valid_i)                     rbr_q  <= rx_data_i;
      if (wr_msts)                        msts_q <= wdata_i;
      else if (rd_msts)                   msts_q[3:0] <= 4'd0;
    end
  end

  always_comb begin
    pset = '0;
    pclr = '0;
    pset[SRC_RX] = rx_valid_i | (wr_lsts & wdata_i[0]);
    pset[SRC_TX] = wr_thr | (wr_lsts & wdata_i[5]);
    pset[SRC_LS] = wr_lsts & (|wdata_i[4:1]);
    pset[SRC_MS] = wr_msts & (|wdata_i[3:0]);
    pclr[SRC_RX] = rd_rbr;
    pclr[SRC_TX] = rd_iid & (iid == {CODE_TX, 1'b0});
    pclr[SRC_LS] = rd_lsts;
    pclr[SRC_MS] = rd_msts;
  end

  uart_rb_pend u_pend (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (pset), .clr_i (pclr), .pend_o (pend)
  );

  uart_rb_lsr #(.DW(DW)) u_lsr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i (wr_lsts), .wdata_i (wdata_i),
    .thr_wr_i (wr_thr), .rbr_rd_i (rd_rbr), .rx_push_i (rx_valid_i),
    .rd_i (rd_lsts), .lsts_o (lsts), .rd_val_o (lsts_rd)
  );

  uart_rb_irq u_irq (
    .pend_i (pend), .ien_i (ien_q), .gate_i (mctl_q[3]),
    .iid_o (iid), .irq_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel[OFF_DATA]: rdata_o = dlab ? dll_q : rbr_q;
      sel[OFF_IEN]:  rdata_o = dlab ? dlm_q : DW'(ien_q);
      sel[OFF_IID]:  rdata_o = DW'({{2{fen_q}}, 2'b00, iid});
      sel[OFF_LCTL]: rdata_o = lctl_q;
      sel[OFF_MCTL]: rdata_o = mctl_q;
      sel[OFF_LSTS]: rdata_o = lsts_rd;
      sel[OFF_MSTS]: rdata_o = msts_q;
      sel[OFF_SCR]:  rdata_o = scr_q;
      default:       rdata_o = '0;
    endcase
  end

  AST_TX_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_thr |=> (tx_valid_o && tx_data_o == $past(wdata_i)));   // R9
  AST_DLAB_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel[OFF_DATA] && dlab) |=> !tx_valid_o);          // R2
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mctl_q[3] && (pend & ien_q) != '0));            // R8
  AST_MSTS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_msts && !wr_msts) |=> (msts_q[3:0] == 4'd0));          // R12
endmodule

// File: tb/uart_rb_top_tb.sv
`timescale 1ns/1ps
module uart_rb_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, rx_valid = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata, tx_data;
  logic       tx_valid, irq;

  always #2.5 clk = ~clk;

  uart_rb_top u_dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_i (wr), .rd_i (rd),
    .wdata_i (wdata), .rdata_o (rdata), .rx_data_i (rx_data),
    .rx_valid_i (rx_valid), .tx_data_o (tx_data), .tx_valid_o (tx_valid),
    .irq_o (irq)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] m_dll = 0, m_dlm = 0, m_lcr = 0, m_mcr = 0, m_lsr = 8'h60;
  logic [7:0] m_msr = 0, m_scr = 0, m_rbr = 0;
  logic [3:0] m_ier = 0;
  logic       m_fen = 0, p_rx = 0, p_tx = 0, p_ls = 0, p_ms = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_iid();
    if (p_ls && m_ier[2]) return 4'h6;
    if (p_rx && m_ier[0]) return 4'h4;
    if (p_tx && m_ier[1]) return 4'h2;
    if (p_ms && m_ier[3]) return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic m_irq();
    return !m_iid()[0] && m_mcr[3];
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
    logic txe;
    @(negedge clk);
    chk({7'd0, irq}, {7'd0, m_irq()}, "R8 irq level");
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
    txe = 1'b0;
    case (a)
      0: if (m_lcr[7]) m_dll = d; else begin txe = 1; m_lsr[5] = 1; p_tx = 1; end
      1: if (m_lcr[7]) m_dlm = d; else m_ier = d[3:0];
      2: m_fen = d[0];
      3: m_lcr = d;
      4: m_mcr = d;
      5: begin m_lsr = d; if (d[0]) p_rx = 1; if (|d[4:1]) p_ls = 1; if (d[5]) p_tx = 1; end
      6: begin m_msr = d; if (|d[3:0]) p_ms = 1; end
      default: m_scr = d;
    endcase
    chk({7'd0, tx_valid}, {7'd0, txe}, txe ? "R9 tx strobe" : "R2 no tx strobe");
    if (txe) chk(tx_data, d, "R9 tx byte");
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    logic [7:0] exp, v;
    @(negedge clk);
    chk({7'd0, irq}, {7'd0, m_irq()}, "R8 irq level");
    addr = a; rd = 1'b1;
    #1;
    case (a)
      0: if (m_lcr[7]) exp = m_dll; else begin exp = m_rbr; m_lsr[0] = 0; p_rx = 0; end
      1: exp = m_lcr[7] ? m_dlm : {4'd0, m_ier};
      2: begin
           exp = {{2{m_fen}}, 2'b00, m_iid()};
           if (m_iid() == 4'h2) p_tx = 0;
         end
      3: exp = m_lcr;
      4: exp = m_mcr;
      5: begin
           v = m_lsr; v[6] = m_lsr[6] | m_lsr[5]; v[5] = 1;
           exp = v; m_lsr = v & 8'he1; p_ls = 0;
         end
      6: begin exp = m_msr; m_msr[3:0] = 0; p_ms = 0; end
      default: exp = m_scr;
    endcase
    chk(rdata, exp, tag);
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(posedge clk); #1; rx_valid = 1'b0;
    m_rbr = b; m_lsr[0] = 1; p_rx = 1;
  endtask

  initial begin
    #500000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk({7'd0, irq}, 8'd0, "R1 irq after reset");
    rd_reg(2, "R1 iid reset"); rd_reg(1, "R1 ien reset");
    rd_reg(3, "R1 lctl reset"); rd_reg(4, "R1 mctl reset");
    rd_reg(5, "R1 lsts reset");

    // R2 divisor aliasing
    wr_reg(3, 8'h83, "R2"); wr_reg(0, 8'h5a, "R2 dll"); wr_reg(1, 8'ha7, "R2 dlm");
    rd_reg(0, "R2 dll read"); rd_reg(1, "R2 dlm read");
    wr_reg(3, 8'h03, "R2");
    rd_reg(1, "R2 ien not touched"); rd_reg(3, "R13 lctl read");

    // R3 mask
    wr_reg(1, 8'hff, "R3"); rd_reg(1, "R3 ien masked");
    wr_reg(1, 8'h00, "R3");

    // R9/R10 tx/rx
    wr_reg(0, 8'h3c, "R9 thr");
    rd_reg(5, "R11 lsts after thr");
    push(8'h96);
    rd_reg(5, "R10 data ready");
    rd_reg(0, "R10 rx byte");
    rd_reg(5, "R10 data ready cleared");

    // R4/R5/R6/R8 priority walk
    wr_reg(4, 8'h08, "R8 out2");
    wr_reg(1, 8'h0f, "R4");
    rd_reg(2, "R6 iid tx from thr write");
    rd_reg(2, "R6 tx cleared");
    wr_reg(5, 8'h3f, "R11 lsts load");
    wr_reg(6, 8'h01, "R12 msts load");
    rd_reg(2, "R4 ls first");
    rd_reg(5, "R11 lsts read");
    rd_reg(2, "R4 rx second");
    rd_reg(0, "R10 read clears rx");
    rd_reg(2, "R4 tx third");
    rd_reg(2, "R4 ms fourth");
    rd_reg(6, "R12 msts read");
    rd_reg(6, "R12 msts cleared");
    rd_reg(2, "R5 idle");
    wr_reg(6, 8'h02, "R12");
    wr_reg(4, 8'h00, "R8 gate off");
    rd_reg(2, "R8 pending, gated");
    wr_reg(4, 8'h08, "R8 gate on");
    rd_reg(6, "R12 msts clear");

    // R7 fifo flag
    wr_reg(2, 8'h01, "R7"); rd_reg(2, "R7 bits 7:6 forced");
    wr_reg(2, 8'h00, "R7"); rd_reg(2, "R7 bits 7:6 clear");

    // R13 scratch
    wr_reg(7, 8'hc3, "R13"); rd_reg(7, "R13 scratch");
    wr_reg(4, 8'h1b, "R13"); rd_reg(4, "R13 mctl read");

    // random mix, R4 model-scored
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 4)      wr_reg(3'($urandom), 8'($urandom), "R4 random write");
      else if (op < 8) rd_reg(3'($urandom), "R4 random read");
      else             push(8'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule